// File: doc/BRIEF.md
# Serial Programming Target Port

This block is the target end of a four-wire serial programming link for a small controller that holds two non-volatile byte arrays: a program array and a data array. A host drives the serial clock and serial data in. The block drives serial data out. An active-low session input opens the link. While the session input is low, the block takes four-byte instructions from the host and acts on them. Before any other instruction has effect, the host must unlock the port with an enable sequence. After that the host can erase both arrays, write or read single bytes in either array, and ask whether a timed write is still in progress.

Both arrays are behavioural register arrays inside the block. Writes to the data array clear the old content before storing the new byte. Writes to the program array can only clear bits. A self-timed busy window follows every write or erase, and new writes or erases are refused during that window.

The serial clock and data are sampled with the system clock through a two-stage synchronizer. Every clock phase is timed, and a phase that is too short raises a sticky error flag.

Top module: `isp_target`

## Requirements
- R1: While `prog_rst_n` is high, the session is closed. The bit position and the unlock state are cleared, serial clock edges are ignored and `miso` is 0. Opening a new session therefore starts at bit 0, locked.
- R2: The instruction `0xAC 0x53 xx xx` unlocks the port once its second byte is received. In the third output byte of that instruction, the target returns `0x53`.
- R3: Before the port is unlocked, every instruction other than the unlock is ignored. Writes and erases change nothing and do not start the busy window, and all output bytes read `0x00`.
- R4: The instruction `0xAC 0x80 xx xx` sets every byte of both arrays to `0xFF` and starts the busy window.
- R5: The instruction `0x40 hi lo d` changes the program byte at address `{hi,lo}` (lowest `PROG_AW` bits) to its old value AND `d`. It does not erase first.
- R6: The instruction `0xC0 hi lo d` replaces the data byte at `{hi,lo}` (lowest `DATA_AW` bits) with `d`, whatever that byte held before.
- R7: The instructions `0x20 hi lo xx` and `0xA0 hi lo xx` return the addressed program byte or data byte, respectively, as the fourth output byte.
- R8: `busy` is high for `BUSY_CYCLES` clock cycles after a write or erase is accepted. Any write or erase that completes while `busy` is high is discarded.
- R9: The instruction `0xF0 xx xx xx` returns `0x01` in its fourth output byte if `busy` is high when that byte is loaded, and `0x00` otherwise.
- R10: If a sampled serial clock phase lasts 2 or fewer system cycles (3 or fewer when `FAST_CLK`=1) during a session, `phase_viol` is set. It stays set until `rst`.
- R11: `mosi` is captured on rising serial clock edges, and `miso` changes only after falling edges. Bytes travel most significant bit first.
- R12: After `rst`, both arrays hold `0xFF`, and `busy`, `phase_viol` and `miso` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_rst_n | input | 1 | Active-low session input; low opens the programming session |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| busy | output | 1 | Self-timed write or erase in progress |
| phase_viol | output | 1 | Sticky flag for a serial clock phase that was too short |

## Verification
The busy window and the arrival of a new write or erase can overlap. This is the timing case that matters. The bench makes it happen by sending a data write, then a busy poll, then a chip erase, back to back, all within the busy window. It repeats the pattern with two data writes in a row. The result is judged at the ports: the poll must return 0x01, and later reads must show the first write's value and no trace of the refused erase or second write. Sweeps across every address of both arrays check the AND rule for program writes and the replace rule for data writes against a model held in the bench.

// File: rtl/isp_pkg.sv
`timescale 1ns/1ps
package isp_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ENABLE,
        CMD_ERASE,
        CMD_PWRITE,
        CMD_PREAD,
        CMD_DWRITE,
        CMD_DREAD,
        CMD_POLL
    } isp_cmd_e;

    // instruction header collected byte by byte
    typedef struct packed {
        logic [7:0] op;
        logic [7:0] arg;
        logic [7:0] alo;
    } isp_hdr_t;

    localparam logic [7:0] OP_ENTER  = 8'hAC;
    localparam logic [7:0] KEY_ENTER = 8'h53;
    localparam logic [7:0] KEY_ERASE = 8'h80;
    localparam logic [7:0] OP_PWRITE = 8'h40;
    localparam logic [7:0] OP_PREAD  = 8'h20;
    localparam logic [7:0] OP_DWRITE = 8'hC0;
    localparam logic [7:0] OP_DREAD  = 8'hA0;
    localparam logic [7:0] OP_POLL   = 8'hF0;

    function automatic isp_cmd_e isp_decode(input logic [7:0] op, input logic [7:0] arg);
        isp_cmd_e c;
        case (op)
            OP_ENTER:  c = (arg == KEY_ENTER) ? CMD_ENABLE :
                           (arg == KEY_ERASE) ? CMD_ERASE  : CMD_NONE;
            OP_PWRITE: c = CMD_PWRITE;
            OP_PREAD:  c = CMD_PREAD;
            OP_DWRITE: c = CMD_DWRITE;
            OP_DREAD:  c = CMD_DREAD;
            OP_POLL:   c = CMD_POLL;
            default:   c = CMD_NONE;
        endcase
        return c;
    endfunction

    // longest serial clock phase, in system cycles, that still counts as too short
    function automatic int unsigned isp_phase_floor(input bit fast);
        return fast ? 3 : 2;
    endfunction

endpackage

// File: rtl/isp_sck_front.sv
`timescale 1ns/1ps
module isp_sck_front
    import isp_pkg::*;
#(
    parameter bit FAST_CLK = 1'b0,
    parameter int CW       = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic sck,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic viol
);
    localparam logic [CW-1:0] LIM = CW'(isp_phase_floor(FAST_CLK));
    localparam logic [CW-1:0] SAT = '1;

    logic [1:0]    sck_q;
    logic [1:0]    mosi_q;
    logic          sck_d;
    logic          edge_seen;
    logic [CW-1:0] phase_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= '0;
            mosi_q <= '0;
            sck_d  <= 1'b0;
        end else begin
            sck_q  <= {sck_q[0], sck};
            mosi_q <= {mosi_q[0], mosi};
            sck_d  <= sck_q[1];
        end
    end

    assign edge_seen = sck_q[1] ^ sck_d;
    assign sck_rise  = active & edge_seen & sck_q[1];
    assign sck_fall  = active & edge_seen & ~sck_q[1];
    assign mosi_s    = mosi_q[1];

    // cycles the current sampled level has lasted, saturating
    always_ff @(posedge clk) begin
        if (rst || !active)
            phase_len <= SAT;
        else if (edge_seen)
            phase_len <= CW'(1);
        else if (phase_len != SAT)
            phase_len <= phase_len + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            viol <= 1'b0;
        else if (active && edge_seen && phase_len <= LIM)
            viol <= 1'b1;
    end

    p_viol_sticky_r10: assert property (@(posedge clk) disable iff (rst) viol |=> viol)
        else $error("phase violation flag dropped without reset");

endmodule

// File: rtl/isp_busy_timer.sv
`timescale 1ns/1ps
module isp_busy_timer #(
    parameter int BUSY_CYCLES = 300,
    parameter int W           = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (start)
            left <= W'(BUSY_CYCLES);
        else if (left != '0)
            left <= left - W'(1);
    end

    assign busy = (left != '0);

    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst) start |-> !busy)
        else $error("write accepted while busy");
    p_busy_follows_r8: assert property (@(posedge clk) disable iff (rst) start |=> busy)
        else $error("busy not raised after start");

endmodule

// File: rtl/isp_target.sv
`timescale 1ns/1ps
module isp_target
    import isp_pkg::*;
#(
    parameter int PROG_AW     = 5,
    parameter int DATA_AW     = 4,
    parameter int BUSY_CYCLES = 300,
    parameter bit FAST_CLK    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_rst_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic busy,
    output logic phase_viol
);
    localparam int PDEPTH = 1 << PROG_AW;
    localparam int DDEPTH = 1 << DATA_AW;

    logic           active;
    logic           sck_rise, sck_fall, mosi_s;
    logic [4:0]     bit_cnt;
    logic [1:0]     byte_idx;
    logic           byte_done, exec;
    logic [7:0]     rx_sr, rx_next, tx_sr, tx_load;
    isp_hdr_t       hdr;
    isp_cmd_e       cmd;
    logic           enabled, wr_go;
    logic [PROG_AW-1:0] paddr;
    logic [DATA_AW-1:0] daddr;
    logic [7:0]     pmem [PDEPTH];
    logic [7:0]     dmem [DDEPTH];

    assign active = ~prog_rst_n;

    isp_sck_front #(.FAST_CLK(FAST_CLK), .CW(4)) u_front (
        .clk(clk), .rst(rst), .active(active), .sck(sck), .mosi(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s), .viol(phase_viol)
    );

    isp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(wr_go), .busy(busy)
    );

    assign rx_next   = {rx_sr[6:0], mosi_s};
    assign byte_idx  = bit_cnt[4:3];
    assign byte_done = sck_rise && (bit_cnt[2:0] == 3'd7);
    assign exec      = byte_done && (byte_idx == 2'd3);
    assign cmd       = isp_decode(hdr.op, hdr.arg);
    assign paddr     = PROG_AW'({hdr.arg, hdr.alo});
    assign daddr     = DATA_AW'({hdr.arg, hdr.alo});
    assign wr_go     = exec && enabled && !busy &&
                       (cmd == CMD_ERASE || cmd == CMD_PWRITE || cmd == CMD_DWRITE);

    // receive side: bit position, header bytes, unlock state
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            hdr     <= '0;
            enabled <= 1'b0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 5'd1;
            rx_sr   <= rx_next;
            if (byte_done) begin
                case (byte_idx)
                    2'd0: hdr.op <= rx_next;
                    2'd1: begin
                        hdr.arg <= rx_next;
                        if (hdr.op == OP_ENTER && rx_next == KEY_ENTER)
                            enabled <= 1'b1;
                    end
                    2'd2: hdr.alo <= rx_next;
                    default: ;
                endcase
            end
        end
    end

    // byte presented at the start of each output byte
    always_comb begin
        tx_load = 8'h00;
        if (enabled) begin
            if (byte_idx == 2'd2 && cmd == CMD_ENABLE)
                tx_load = KEY_ENTER;
            else if (byte_idx == 2'd3) begin
                case (cmd)
                    CMD_PREAD: tx_load = pmem[paddr];
                    CMD_DREAD: tx_load = dmem[daddr];
                    CMD_POLL:  tx_load = {7'b0, busy};
                    default:   tx_load = 8'h00;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active)
            tx_sr <= '0;
        else if (sck_fall) begin
            if (bit_cnt[2:0] == 3'd0)
                tx_sr <= tx_load;
            else
                tx_sr <= {tx_sr[6:0], 1'b0};
        end
    end

    assign miso = tx_sr[7];

    // behavioural arrays
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PDEPTH; i++) pmem[i] <= 8'hFF;
            for (int j = 0; j < DDEPTH; j++) dmem[j] <= 8'hFF;
        end else if (wr_go) begin
            case (cmd)
                CMD_ERASE: begin
                    for (int i = 0; i < PDEPTH; i++) pmem[i] <= 8'hFF;
                    for (int j = 0; j < DDEPTH; j++) dmem[j] <= 8'hFF;
                end
                CMD_PWRITE: pmem[paddr] <= pmem[paddr] & rx_next;
                CMD_DWRITE: dmem[daddr] <= rx_next;
                default: ;
            endcase
        end
    end

    p_exit_clears_r1: assert property (@(posedge clk) disable iff (rst)
        prog_rst_n |=> (!enabled && bit_cnt == 5'd0 && !miso))
        else $error("closed session left state behind");
    p_miso_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!prog_rst_n && !sck_fall) |=> $stable(miso))
        else $error("miso moved without a falling edge");

endmodule

// File: tb/isp_target_test.sv
`timescale 1ns/1ps
module isp_target_test;
    localparam int PAW  = 5;
    localparam int DAW  = 4;
    localparam int BUSY = 600;
    localparam int PN   = 1 << PAW;
    localparam int DN   = 1 << DAW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_rst_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, busy, phase_viol;

    always #2.5 clk = ~clk;

    isp_target #(.PROG_AW(PAW), .DATA_AW(DAW), .BUSY_CYCLES(BUSY), .FAST_CLK(1'b0)) uut (
        .clk(clk), .rst(rst), .prog_rst_n(prog_rst_n), .sck(sck), .mosi(mosi),
        .miso(miso), .busy(busy), .phase_viol(phase_viol)
    );

    int n_chk = 0;
    int n_bad = 0;
    int half = 4;
    int hi_moves = 0;
    logic [7:0] pm [PN];
    logic [7:0] dm [DN];
    logic [31:0] r;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input logic [7:0] b3, output logic [31:0] got);
        logic [31:0] w;
        w = {b0, b1, b2, b3};
        for (int i = 31; i >= 0; i--) begin
            mosi = w[i];
            idle(half);
            got[i] = miso;
            sck = 1'b1;
            idle(half);
            if (miso !== got[i]) hi_moves++;
            sck = 1'b0;
        end
        mosi = 1'b0;
    endtask

    task automatic wait_idle();
        idle(2);
        while (busy) @(negedge clk);
        idle(4);
    endtask

    function automatic logic [7:0] pat1(input int a);
        return 8'(a * 37 + 5);
    endfunction
    function automatic logic [7:0] pat2(input int a);
        return 8'(a * 91 + 60) ^ 8'hA5;
    endfunction

    initial begin
        for (int a = 0; a < PN; a++) pm[a] = 8'hFF;
        for (int a = 0; a < DN; a++) dm[a] = 8'hFF;
        idle(4);
        rst = 1'b0;
        idle(2);
        check("R12 miso after reset", {31'b0, miso}, 32'd0);
        check("R12 busy after reset", {31'b0, busy}, 32'd0);
        check("R12 phase_viol after reset", {31'b0, phase_viol}, 32'd0);

        prog_rst_n = 1'b0;
        idle(8);
        // locked port
        xfer(8'h20, 8'h00, 8'h00, 8'h00, r);
        check("R3 locked read returns zero", r, 32'd0);
        xfer(8'hC0, 8'h00, 8'h03, 8'h77, r);
        idle(2);
        check("R3 locked write starts no busy", {31'b0, busy}, 32'd0);
        xfer(8'hAC, 8'h80, 8'h00, 8'h00, r);
        idle(2);
        check("R3 locked erase starts no busy", {31'b0, busy}, 32'd0);

        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        check("R2 unlock echo", {24'b0, r[15:8]}, 32'h53);
        check("R2 other unlock bytes", {r[31:16], r[7:0]}, 32'd0);
        xfer(8'hA0, 8'h00, 8'h03, 8'h00, r);
        check("R3 locked write left data byte", {24'b0, r[7:0]}, 32'hFF);
        xfer(8'h20, 8'h00, 8'h07, 8'h00, r);
        check("R12 program array reset to FF", {24'b0, r[7:0]}, 32'hFF);

        // program array: first pattern then AND with second
        for (int a = 0; a < PN; a++) begin
            xfer(8'h40, 8'h00, 8'(a), pat1(a), r);
            pm[a] = pm[a] & pat1(a);
            wait_idle();
        end
        for (int a = 0; a < PN; a++) begin
            xfer(8'h20, 8'h00, 8'(a), 8'h00, r);
            check($sformatf("R7 R5 program read addr %0d", a), {24'b0, r[7:0]}, {24'b0, pm[a]});
        end
        for (int a = 0; a < PN; a++) begin
            xfer(8'h40, 8'h00, 8'(a), pat2(a), r);
            pm[a] = pm[a] & pat2(a);
            wait_idle();
        end
        for (int a = 0; a < PN; a++) begin
            xfer(8'h20, 8'h00, 8'(a), 8'h00, r);
            check($sformatf("R5 program AND addr %0d", a), {24'b0, r[7:0]}, {24'b0, pm[a]});
        end

        // data array: replace semantics
        for (int a = 0; a < DN; a++) begin
            xfer(8'hC0, 8'h00, 8'(a), pat1(a + 7), r);
            dm[a] = pat1(a + 7);
            wait_idle();
        end
        for (int a = 0; a < DN; a++) begin
            xfer(8'hA0, 8'h00, 8'(a), 8'h00, r);
            check($sformatf("R7 R6 data read addr %0d", a), {24'b0, r[7:0]}, {24'b0, dm[a]});
        end
        for (int a = 0; a < 8; a++) begin
            xfer(8'hC0, 8'h00, 8'(a), pat2(a), r);
            dm[a] = pat2(a);
            wait_idle();
        end
        for (int a = 0; a < 8; a++) begin
            xfer(8'hA0, 8'h00, 8'(a), 8'h00, r);
            check($sformatf("R6 data rewrite addr %0d", a), {24'b0, r[7:0]}, {24'b0, dm[a]});
        end

        // busy window against new writes and erase
        xfer(8'hC0, 8'h00, 8'h05, 8'h3C, r);
        dm[5] = 8'h3C;
        idle(1);
        check("R8 busy after accepted write", {31'b0, busy}, 32'd1);
        xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
        check("R9 poll while busy", {24'b0, r[7:0]}, 32'h01);
        xfer(8'hAC, 8'h80, 8'h00, 8'h00, r);
        wait_idle();
        xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
        check("R9 poll when idle", {24'b0, r[7:0]}, 32'h00);
        xfer(8'hA0, 8'h00, 8'h05, 8'h00, r);
        check("R8 erase during busy ignored", {24'b0, r[7:0]}, 32'h3C);
        xfer(8'hC0, 8'h00, 8'h09, 8'h12, r);
        dm[9] = 8'h12;
        xfer(8'hC0, 8'h00, 8'h0A, 8'h34, r);
        wait_idle();
        xfer(8'hA0, 8'h00, 8'h0A, 8'h00, r);
        check("R8 write during busy ignored", {24'b0, r[7:0]}, {24'b0, dm[10]});
        xfer(8'hA0, 8'h00, 8'h09, 8'h00, r);
        check("R8 first write kept", {24'b0, r[7:0]}, 32'h12);

        // chip erase
        xfer(8'hAC, 8'h80, 8'h00, 8'h00, r);
        idle(1);
        check("R4 erase raises busy", {31'b0, busy}, 32'd1);
        wait_idle();
        for (int a = 0; a < PN; a++) begin
            xfer(8'h20, 8'h00, 8'(a), 8'h00, r);
            check($sformatf("R4 program erased addr %0d", a), {24'b0, r[7:0]}, 32'hFF);
        end
        for (int a = 0; a < DN; a++) begin
            xfer(8'hA0, 8'h00, 8'(a), 8'h00, r);
            check($sformatf("R4 data erased addr %0d", a), {24'b0, r[7:0]}, 32'hFF);
        end
        xfer(8'hC0, 8'h00, 8'h02, 8'h5A, r);
        wait_idle();

        // abort mid instruction
        for (int k = 0; k < 12; k++) begin
            mosi = 1'b1; idle(half); sck = 1'b1; idle(half); sck = 1'b0;
        end
        mosi = 1'b0;
        prog_rst_n = 1'b1;
        idle(4);
        check("R1 miso low with session closed", {31'b0, miso}, 32'd0);
        for (int k = 0; k < 5; k++) begin
            sck = 1'b1; idle(half); sck = 1'b0; idle(half);
        end
        prog_rst_n = 1'b0;
        idle(4);
        xfer(8'hA0, 8'h00, 8'h02, 8'h00, r);
        check("R1 unlock cleared on exit", r, 32'd0);
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        check("R1 fresh bit alignment", {24'b0, r[15:8]}, 32'h53);
        xfer(8'hA0, 8'h00, 8'h02, 8'h00, r);
        check("R6 data survives session exit", {24'b0, r[7:0]}, 32'h5A);

        check("R11 miso steady through high phases", hi_moves, 32'd0);

        // phase timing
        half = 3;
        xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
        check("R10 three-cycle phases accepted", {31'b0, phase_viol}, 32'd0);
        check("R9 poll at minimum timing", {24'b0, r[7:0]}, 32'h00);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; idle(2); sck = 1'b0; idle(2);
        end
        idle(6);
        check("R10 two-cycle phase flagged", {31'b0, phase_viol}, 32'd1);
        prog_rst_n = 1'b1;
        idle(10);
        check("R10 flag sticky after session exit", {31'b0, phase_viol}, 32'd1);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(2);
        check("R10 flag cleared by reset", {31'b0, phase_viol}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule